// File: doc/BRIEF.md
# ASCII Hex Record Memory Loader

This block takes a stream of ASCII characters, one per valid/ready handshake, and parses them as text load records. Each record line holds a load address in hex, a byte count in hex, and then that many hex data bytes. Each data byte is stored in an internal byte-wide memory. The first byte goes to the record address and each following byte goes to the next address. Text after the last counted byte, up to the line feed, is treated as a comment and skipped.

Characters that are not upper-case hex digits, arriving where a digit is expected, raise a sticky error flag. The rest of that line is then dropped. A combinational read port lets a host or a bench inspect the memory after loading. The memory is 2^AW bytes, and only the low AW bits of the record address are used.

Top module: `hexrec_loader`

## Requirements
- R1: A record begins with exactly four hex digits of address. Spaces (0x20) and carriage returns (0x0D) before the first address digit are skipped. The first data byte is written at the low AW bits of that address.
- R2: Digit decoding works as follows. Codes 0x30 to 0x39 give 0 to 9, and codes 0x41 to 0x46 give 10 to 15. Any other code where a digit is expected is invalid and sets err_flag. This includes 0x3A to 0x40 and lower-case 0x61 to 0x66.
- R3: The count follows the address after whitespace. It is read as one or more hex digits, ended by a space or carriage return, and extra whitespace before it is skipped.
- R4: Data bytes are two hex digits each and go to consecutive addresses. The address wraps from 2^AW-1 to 0.
- R5: After the counted bytes, every character up to the line feed is ignored and writes nothing.
- R6: A count of zero writes no byte, and the rest of the line is ignored.
- R7: err_flag stays set until reset. After an invalid character, the rest of the line is skipped, a half-received byte is not written, and the next line is parsed normally.
- R8: A line feed (0x0A) in any parser state ends the record, with no error. Bytes completed before it stay written, and the parser then expects an address.
- R9: After reset in_ready is high. It is low for exactly the one cycle that follows acceptance of a byte's second digit, and high at every other time.
- R10: The second digit of a data byte must be followed by whitespace. Any other character sets err_flag, and the byte just completed remains written. Extra spaces between data bytes are accepted.
- R11: Reset clears err_flag and returns the parser to expecting an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character present on in_data |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Character accepted when high together with in_valid |
| rd_addr | input | AW | Memory read address |
| rd_data | output | 8 | Memory byte at rd_addr (combinational) |
| err_flag | output | 1 | Sticky invalid-character flag |

## Verification
Well-formed records are sent in several shapes, and each shape separates one piece of the parser from another:
- leading carriage returns;
- multi-digit counts with padded spacing;
- a record that crosses the top of memory;
- one digit from every part of the hex range.

Records that overlay earlier data show whether the comment tail and a zero count really suppress writes, by reading back bytes the tail could have hit.

Malformed lines check four things:
- the punctuation between '9' and 'A' and lower-case letters are rejected;
- a missing separator leaves the completed byte in place but not the next one;
- a line cut short by a line feed keeps only whole bytes;
- the flag survives a later clean record.

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          err_flag
);

  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] S_ADDR = 3'd0, S_ASEP = 3'd1, S_CNT = 3'd2,
                         S_DHI  = 3'd3, S_DLO  = 3'd4, S_DSEP = 3'd5,
                         S_SKIP = 3'd6;

  logic [2:0]    st;
  logic [2:0]    ndig;
  logic [AW-1:0] addr_acc;
  logic [CW-1:0] cnt;
  logic          cnt_seen;
  logic [3:0]    hi_nib;
  logic [AW-1:0] ptr;
  logic          wr_pend;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_byte;
  logic [7:0]    mem [DEPTH];
  logic [4:0]    nib;

  wire acc   = in_valid & in_ready;
  wire is_lf = (in_data == 8'h0A);
  wire is_ws = (in_data == 8'h20) || (in_data == 8'h0D);

  always_comb begin
    if (in_data >= 8'h30 && in_data <= 8'h39)
      nib = {1'b0, in_data[3:0]};
    else if (in_data >= 8'h41 && in_data <= 8'h46)
      nib = {1'b0, in_data[3:0] + 4'd9};
    else
      nib = 5'h10;
  end

  wire       bad = nib[4];
  wire [3:0] nv  = nib[3:0];

  assign in_ready = ~wr_pend;
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_pend) mem[wr_addr] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_ADDR;
      ndig     <= '0;
      addr_acc <= '0;
      cnt      <= '0;
      cnt_seen <= 1'b0;
      hi_nib   <= '0;
      ptr      <= '0;
      wr_pend  <= 1'b0;
      wr_addr  <= '0;
      wr_byte  <= '0;
      err_flag <= 1'b0;
    end else begin
      wr_pend <= 1'b0;
      if (acc) begin
        if (is_lf) begin
          st   <= S_ADDR;
          ndig <= '0;
        end else begin
          case (st)
            S_ADDR: begin
              if (is_ws && ndig == 3'd0) begin
              end else if (bad) begin
                st <= S_SKIP; err_flag <= 1'b1;
              end else begin
                addr_acc <= (addr_acc << 4) | AW'(nv);
                ndig     <= ndig + 3'd1;
                if (ndig == 3'd3) st <= S_ASEP;
              end
            end
            S_ASEP: begin
              if (is_ws) begin
                st       <= S_CNT;
                cnt      <= '0;
                cnt_seen <= 1'b0;
                ptr      <= addr_acc;
              end else begin
                st <= S_SKIP; err_flag <= 1'b1;
              end
            end
            S_CNT: begin
              if (is_ws) begin
                if (cnt_seen) st <= (cnt == '0) ? S_SKIP : S_DHI;
              end else if (bad) begin
                st <= S_SKIP; err_flag <= 1'b1;
              end else begin
                cnt      <= (cnt << 4) | CW'(nv);
                cnt_seen <= 1'b1;
              end
            end
            S_DHI: begin
              if (is_ws) begin
              end else if (bad) begin
                st <= S_SKIP; err_flag <= 1'b1;
              end else begin
                hi_nib <= nv;
                st     <= S_DLO;
              end
            end
            S_DLO: begin
              if (bad) begin
                st <= S_SKIP; err_flag <= 1'b1;
              end else begin
                wr_pend <= 1'b1;
                wr_addr <= ptr;
                wr_byte <= {hi_nib, nv};
                ptr     <= ptr + AW'(1);
                cnt     <= cnt - CW'(1);
                st      <= S_DSEP;
              end
            end
            S_DSEP: begin
              if (is_ws) st <= (cnt == '0) ? S_SKIP : S_DHI;
              else begin
                st <= S_SKIP; err_flag <= 1'b1;
              end
            end
            default: begin
            end
          endcase
        end
      end
    end
  end

endmodule

module hexrec_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       err_flag,
  input logic [2:0] st
);

  wire take = in_valid && in_ready;

  a_r9_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  a_r9_stall_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> ($past(take) && $past(st) == 3'd4));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r8_lf_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_data == 8'h0A) |=> st == 3'd0);

  a_r5_comment_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st == 3'd6) |=> in_ready);

  a_r2_lower_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (st == 3'd3 || st == 3'd4) && in_data >= 8'h61 && in_data <= 8'h66)
      |=> err_flag);

endmodule

bind hexrec_loader hexrec_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .err_flag(err_flag), .st(st)
);

// File: tb/test_hexrec_loader.sv
module test_hexrec_loader;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          err_flag;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  hexrec_loader #(.AW(AW), .CW(8)) i_hexrec_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .err_flag(err_flag)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_char(logic [7:0] c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_str(string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic read_chk(string req, logic [AW-1:0] a, logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic t_reset;
    check("R11 ready after reset", {7'd0, in_ready}, 8'd1);
    check("R11 err after reset", {7'd0, err_flag}, 8'd0);
  endtask

  task automatic t_basic;
    logic [7:0] exp [7] = '{8'hAE, 8'h03, 8'hB6, 8'h91, 8'hC7, 8'h00, 8'h0C};
    send_str("12AC 7 AE 03 B6 91 C7 00 0C trailing words\n");
    for (int i = 0; i < 7; i++) read_chk("R1 R4 basic record", 8'hAC + 8'(i), exp[i]);
  endtask

  task automatic t_stall;
    send_str("0010 1 5");
    send_char("A");
    check("R9 ready low after byte", {7'd0, in_ready}, 8'd0);
    @(negedge clk);
    check("R9 ready back high", {7'd0, in_ready}, 8'd1);
    send_str(" \n");
    read_chk("R9 stalled byte written", 8'h10, 8'h5A);
  endtask

  task automatic t_whitespace;
    send_char(8'h0D);
    send_str("0050");
    send_char(8'h0D);
    send_str("2 FF EE\n");
    read_chk("R1 R8 cr and lf", 8'h50, 8'hFF);
    read_chk("R8 last byte before lf", 8'h51, 8'hEE);
    send_str("  0030   03  7E  81 3C \n");
    read_chk("R3 R10 padded count", 8'h30, 8'h7E);
    read_chk("R3 R10 padded count", 8'h31, 8'h81);
    read_chk("R3 R10 padded count", 8'h32, 8'h3C);
  endtask

  task automatic t_comment_and_zero;
    send_str("0060 4 11 22 33 44 \n");
    send_str("0060 2 AA BB CC DD\n");
    read_chk("R5 counted byte", 8'h61, 8'hBB);
    read_chk("R5 comment not written", 8'h62, 8'h33);
    read_chk("R5 comment not written", 8'h63, 8'h44);
    send_str("0062 0 99 88\n");
    read_chk("R6 zero count", 8'h62, 8'h33);
    read_chk("R6 zero count", 8'h63, 8'h44);
  endtask

  task automatic t_hex_and_wrap;
    send_str("0070 6 9A FF 0B F0 A0 5C \n");
    read_chk("R2 digit 9A", 8'h70, 8'h9A);
    read_chk("R2 digit FF", 8'h71, 8'hFF);
    read_chk("R2 digit 0B", 8'h72, 8'h0B);
    read_chk("R2 digit A0", 8'h74, 8'hA0);
    send_str("00FE 3 01 02 03 \n");
    read_chk("R4 wrap top", 8'hFF, 8'h02);
    read_chk("R4 wrap to zero", 8'h00, 8'h03);
  endtask

  task automatic t_lf_cut;
    send_str("0090 4 00 00 00 00 \n");
    send_str("0090 3 A1 B\n0093 1 C3 \n");
    read_chk("R8 whole byte kept", 8'h90, 8'hA1);
    read_chk("R8 half byte dropped", 8'h91, 8'h00);
    read_chk("R8 next line parsed", 8'h93, 8'hC3);
    check("R8 lf no error", {7'd0, err_flag}, 8'd0);
  endtask

  task automatic t_errors;
    send_str("0080 2 55 66 \n");
    send_str("0080 2 12x34 \n");
    check("R10 err on missing space", {7'd0, err_flag}, 8'd1);
    read_chk("R10 completed byte kept", 8'h80, 8'h12);
    read_chk("R10 next byte not written", 8'h81, 8'h66);
    send_str("0070 2 1: 77 \n");
    read_chk("R2 R7 colon rejected", 8'h70, 8'h9A);
    read_chk("R7 rest skipped", 8'h71, 8'hFF);
    send_str("0075 1 ab \n");
    read_chk("R2 lower case rejected", 8'h75, 8'h5C);
    send_str("0072 G 33 \n");
    read_chk("R2 R3 bad count", 8'h72, 8'h0B);
    send_str("0074 1 D4 \n");
    read_chk("R7 recovery line", 8'h74, 8'hD4);
    check("R7 err sticky", {7'd0, err_flag}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_stall;
    t_whitespace;
    t_comment_and_zero;
    t_hex_and_wrap;
    t_lf_cut;
    check("R7 no error yet", {7'd0, err_flag}, 8'd0);
    t_errors;
    report;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    report;
    $finish;
  end
endmodule